// File: doc/BRIEF.md
# Randomized Root Contention Arbiter

This block is one node's half of the tie-break used during tree identification on a serial bus. It applies when two neighbouring nodes each ask the other to be parent. Each side sends idle and then backs off for a randomly drawn short or long interval. When the interval runs out, the side that has heard the peer go idle sends a request. The side that is still hearing a request answers it with an acknowledge. The node that drew the longer interval therefore ends as root, and its peer ends as child. When both nodes draw the same length, the two requests cross on the link, both nodes fall back to contention and draw again.

The arbiter exchanges one link symbol per clock in each direction. A 16-bit pseudo-random shift register supplies the short/long choice. A single cycle counter measures the backoff. The states, with their names in the RTL, are:

- `ST_CONTEND`: contention.
- `ST_HEARD_IDLE`: peer idle seen.
- `ST_REQ_FAST` and `ST_REQ_SLOW`: backing off while the peer still requests.
- `ST_IDLE_FAST` and `ST_IDLE_SLOW`: backing off after the peer went idle.
- `ST_SENT_REQ`: request sent.
- `ST_NEAR_ROOT` and `ST_NEAR_CHILD`: the two terminal states.

The transitions are:

- contend→heard-idle on a received idle; otherwise contend→req-wait, sending idle.
- heard-idle→contend on a received request; otherwise heard-idle→idle-wait, sending idle.
- req-wait↔idle-wait on a received idle or request, keeping the same speed.
- req-wait→near-root on expiry, sending acknowledge.
- idle-wait→sent-request on expiry, sending request.
- sent-request→contend on a received request.
- sent-request→near-child on a received acknowledge.

A `restart` pulse sends any state back to contention.

Top module: `rc_arbiter`

## Requirements
- R1: While `rst_n` is low, the node is in contention, `tx_sym` is 0, `done` is 0 and `is_root` is 0, and the shift register loads `SEED`. In the first cycle after release with no received symbol, the node sends idle.
- R2: Link symbols are 2-bit codes: 0 none, 1 request, 2 acknowledge, 3 idle. `tx_sym` is registered. It carries a symbol for exactly one cycle per transition that sends one and is 0 at all other times.
- R3: The shift register advances every clock after reset, including across restarts. The update shifts left and sets the new bit 0 to the XOR of bits 15, 13, 12 and 10. A transition that sends idle picks the slow window when bit 0 of the current register value is 1, and the fast window otherwise.
- R4: Contention is never held for more than one cycle. A received idle moves the node to heard-idle without sending anything. Any other input sends idle and starts a request-side wait with the counter at zero.
- R5: Heard-idle is never held for more than one cycle. A received request returns the node to contention with nothing sent. Any other input sends idle and starts an idle-side wait with the counter at zero.
- R6: In a request-side wait, a received idle moves the node to the idle-side wait of the same speed. Expiry sends acknowledge and enters near-root, and `done` and `is_root` rise in the same cycle as that acknowledge.
- R7: In an idle-side wait, a received request moves the node to the request-side wait of the same speed. Expiry sends request and enters sent-request. Neither move clears the counter.
- R8: The counter reaches the window minimum (`FAST_MIN` or `SLOW_MIN`) in the cycle it expires. With no symbol received in that cycle, the outgoing symbol appears exactly minimum+1 cycles after the idle that opened the wait. The counter never exceeds the window maximum.
- R9: A received idle or request that moves the node between wait states takes priority over expiry in the same cycle. The outgoing symbol is then delayed by one cycle.
- R10: In sent-request, a received request returns the node to contention, and it sends idle on the following cycle. A received acknowledge enters near-child. A received idle has no effect.
- R11: Near-root and near-child hold until `restart`. They ignore every received symbol and send nothing. `done` is 1 in both, and `is_root` is 1 only in near-root.
- R12: `restart` puts the node in contention on the next edge from any state, clearing `done`. The node sends idle in the cycle after `restart` falls.
- R13: In a request-side wait, a received request or acknowledge is ignored. In an idle-side wait, a received idle or acknowledge is ignored. An ignored symbol changes neither the state nor the expiry time.
- R14: Two arbiters joined by links of equal delay, with `FAST_MAX` plus the delay below `SLOW_MIN`, always finish with one in near-root and the other in near-child.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Return to contention on the next edge |
| rx_sym | input | 2 | Symbol received from the peer link this cycle |
| tx_sym | output | 2 | Symbol sent toward the peer link, one cycle wide |
| done | output | 1 | Node has reached a terminal state |
| is_root | output | 1 | Terminal state is root (valid while done) |

## Verification
The embedded properties assume that `FAST_MIN` is below `FAST_MAX`, that `SLOW_MIN` is below `SLOW_MAX`, and that `SEED` is non-zero. They also assume that `rx_sym` carries at most one symbol per cycle, which is what a peer of this kind produces. The directed sweeps drive single-cycle symbols at chosen offsets inside each backoff. These include the exact expiry cycle, which exercises the priority rule. The two-node rounds join the arbiters through three-stage delay lines. Those lines, together with windows scaled down to 20/24 and 44/48 cycles, keep the delay inside the gap between the fast maximum and the slow minimum. Restart is held until both lines have drained, so no stale symbol reaches either node.

// File: rtl/rc_arb_pkg.sv
package rc_arb_pkg;

    localparam int LFSR_W = 16;

    typedef enum logic [1:0] {
        SYM_NONE = 2'd0,
        SYM_REQ  = 2'd1,
        SYM_ACK  = 2'd2,
        SYM_IDLE = 2'd3
    } rc_sym_e;

    typedef enum logic [3:0] {
        ST_CONTEND,
        ST_HEARD_IDLE,
        ST_REQ_FAST,
        ST_REQ_SLOW,
        ST_IDLE_FAST,
        ST_IDLE_SLOW,
        ST_SENT_REQ,
        ST_NEAR_ROOT,
        ST_NEAR_CHILD
    } rc_state_e;

    function automatic logic st_is_wait(rc_state_e s);
        return (s == ST_REQ_FAST) || (s == ST_REQ_SLOW) ||
               (s == ST_IDLE_FAST) || (s == ST_IDLE_SLOW);
    endfunction

    function automatic logic st_is_slow(rc_state_e s);
        return (s == ST_REQ_SLOW) || (s == ST_IDLE_SLOW);
    endfunction

    function automatic logic st_is_final(rc_state_e s);
        return (s == ST_NEAR_ROOT) || (s == ST_NEAR_CHILD);
    endfunction

endpackage

// File: rtl/rc_lfsr.sv
module rc_lfsr
    import rc_arb_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'hACE1,
    parameter logic [LFSR_W-1:0] TAPS = 16'hB400
) (
    input  logic clk,
    input  logic rst_n,
    output logic pick_slow
);

    logic [LFSR_W-1:0] sr_q;
    logic              fb;

    assign fb        = ^(sr_q & TAPS);
    assign pick_slow = sr_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) sr_q <= SEED;
        else        sr_q <= {sr_q[LFSR_W-2:0], fb};
    end

    // R3: the register never collapses to the all-zero lock-up value
    a_r3_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
        sr_q != '0);

endmodule

// File: rtl/rc_backoff_timer.sv
module rc_backoff_timer #(
    parameter int FAST_MIN = 760,
    parameter int FAST_MAX = 850,
    parameter int SLOW_MIN = 1590,
    parameter int SLOW_MAX = 1670
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic slow_in,
    input  logic inc,
    output logic at_min,
    output logic slow_q
);

    localparam int CW = $clog2(SLOW_MAX + 2);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] min_sel;
    logic [CW-1:0] max_sel;

    assign min_sel = slow_q ? CW'(SLOW_MIN) : CW'(FAST_MIN);
    assign max_sel = slow_q ? CW'(SLOW_MAX) : CW'(FAST_MAX);
    assign at_min  = (cnt_q >= min_sel);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            slow_q <= 1'b0;
        end else if (clr) begin
            cnt_q  <= '0;
            slow_q <= slow_in;
        end else if (inc) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R8: the wait never runs past the upper bound of its window
    a_r8_within_max: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= max_sel);

    // R8: counting stops once the bound is hit, i.e. nobody increments at the maximum
    a_r8_no_inc_at_max: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |-> (cnt_q < max_sel));

endmodule

// File: rtl/rc_arbiter.sv
module rc_arbiter
    import rc_arb_pkg::*;
#(
    parameter int                FAST_MIN = 760,
    parameter int                FAST_MAX = 850,
    parameter int                SLOW_MIN = 1590,
    parameter int                SLOW_MAX = 1670,
    parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic [1:0] rx_sym,
    output logic [1:0] tx_sym,
    output logic       done,
    output logic       is_root
);

    rc_state_e st_q, st_nxt;
    rc_sym_e   rx;
    rc_sym_e   tx_nxt, tx_q;
    logic      done_q, root_q;
    logic      pick_slow;
    logic      t_clr, t_inc, t_at_min, t_slow;

    assign rx = rc_sym_e'(rx_sym);

    rc_lfsr #(
        .SEED (SEED),
        .TAPS (16'hB400)
    ) u_lfsr (
        .clk       (clk),
        .rst_n     (rst_n),
        .pick_slow (pick_slow)
    );

    rc_backoff_timer #(
        .FAST_MIN (FAST_MIN),
        .FAST_MAX (FAST_MAX),
        .SLOW_MIN (SLOW_MIN),
        .SLOW_MAX (SLOW_MAX)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (t_clr),
        .slow_in (pick_slow),
        .inc     (t_inc),
        .at_min  (t_at_min),
        .slow_q  (t_slow)
    );

    // next-state and transmit decision
    always_comb begin
        st_nxt = st_q;
        tx_nxt = SYM_NONE;
        t_clr  = 1'b0;
        t_inc  = 1'b0;
        if (restart) begin
            st_nxt = ST_CONTEND;
        end else begin
            unique case (st_q)
                ST_CONTEND: begin
                    if (rx == SYM_IDLE) begin
                        st_nxt = ST_HEARD_IDLE;
                    end else begin
                        st_nxt = pick_slow ? ST_REQ_SLOW : ST_REQ_FAST;
                        tx_nxt = SYM_IDLE;
                        t_clr  = 1'b1;
                    end
                end
                ST_HEARD_IDLE: begin
                    if (rx == SYM_REQ) begin
                        st_nxt = ST_CONTEND;
                    end else begin
                        st_nxt = pick_slow ? ST_IDLE_SLOW : ST_IDLE_FAST;
                        tx_nxt = SYM_IDLE;
                        t_clr  = 1'b1;
                    end
                end
                ST_REQ_FAST, ST_REQ_SLOW: begin
                    if (rx == SYM_IDLE) begin
                        st_nxt = (st_q == ST_REQ_SLOW) ? ST_IDLE_SLOW : ST_IDLE_FAST;
                        t_inc  = 1'b1;
                    end else if (t_at_min) begin
                        st_nxt = ST_NEAR_ROOT;
                        tx_nxt = SYM_ACK;
                    end else begin
                        t_inc  = 1'b1;
                    end
                end
                ST_IDLE_FAST, ST_IDLE_SLOW: begin
                    if (rx == SYM_REQ) begin
                        st_nxt = (st_q == ST_IDLE_SLOW) ? ST_REQ_SLOW : ST_REQ_FAST;
                        t_inc  = 1'b1;
                    end else if (t_at_min) begin
                        st_nxt = ST_SENT_REQ;
                        tx_nxt = SYM_REQ;
                    end else begin
                        t_inc  = 1'b1;
                    end
                end
                ST_SENT_REQ: begin
                    if (rx == SYM_REQ)      st_nxt = ST_CONTEND;
                    else if (rx == SYM_ACK) st_nxt = ST_NEAR_CHILD;
                end
                ST_NEAR_ROOT, ST_NEAR_CHILD: begin
                    st_nxt = st_q;
                end
                default: st_nxt = ST_CONTEND;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_CONTEND;
        else        st_q <= st_nxt;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_q   <= SYM_NONE;
            done_q <= 1'b0;
            root_q <= 1'b0;
        end else begin
            tx_q   <= tx_nxt;
            done_q <= st_is_final(st_nxt);
            root_q <= (st_nxt == ST_NEAR_ROOT);
        end
    end

    assign tx_sym  = tx_q;
    assign done    = done_q;
    assign is_root = root_q;

    // R4: contention is urgent
    a_r4_contend_urgent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_CONTEND && !restart) |=> (st_q != ST_CONTEND));

    // R5: heard-idle is urgent
    a_r5_heard_idle_urgent: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HEARD_IDLE && !restart) |=> (st_q != ST_HEARD_IDLE));

    // R11: terminal states hold until restart
    a_r11_terminal_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_is_final(st_q) && !restart) |=> $stable(st_q));

    // R2: a symbol only leaves on a state change
    a_r2_tx_on_change: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q != SYM_NONE) |-> (st_q != $past(st_q)));

    // R6: acknowledge coincides with the root indication
    a_r6_ack_is_root: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q == SYM_ACK) |-> (done_q && root_q && st_q == ST_NEAR_ROOT));

    // R7: a request leaves only on entry to sent-request
    a_r7_req_sent_state: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_q == SYM_REQ) |-> (st_q == ST_SENT_REQ));

    // R6: the wait speed in the state matches the window held by the counter
    a_r6_speed_kept: assert property (@(posedge clk) disable iff (!rst_n)
        st_is_wait(st_q) |-> (st_is_slow(st_q) == t_slow));

    // R11: done marks exactly the terminal states
    a_r11_done_final: assert property (@(posedge clk) disable iff (!rst_n)
        done_q == st_is_final(st_q));

endmodule

// File: tb/tb_rc_arbiter.sv
module tb_rc_arbiter;

    localparam int FM  = 20;
    localparam int FX  = 24;
    localparam int SM  = 44;
    localparam int SX  = 48;
    localparam int DLY = 3;
    localparam logic [15:0] SEED_A = 16'hACE1;
    localparam logic [15:0] SEED_B = 16'h1D2C;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       restart = 1'b0;
    logic       link_mode = 1'b0;
    logic [1:0] drv_rx = 2'd0;
    logic [1:0] dut_rx, dut_tx, peer_tx;
    logic       dut_done, dut_root, peer_done, peer_root;
    logic [1:0] l12 [DLY];
    logic [1:0] l21 [DLY];
    logic [15:0] mdl;
    logic       prev_bit;
    logic       last_slow;
    int         n_chk = 0;
    int         n_bad = 0;

    always #2 clk = ~clk;

    assign dut_rx = link_mode ? l21[DLY-1] : drv_rx;

    rc_arbiter #(.FAST_MIN(FM), .FAST_MAX(FX), .SLOW_MIN(SM), .SLOW_MAX(SX), .SEED(SEED_A)) dut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .rx_sym(dut_rx),
        .tx_sym(dut_tx), .done(dut_done), .is_root(dut_root));

    rc_arbiter #(.FAST_MIN(FM), .FAST_MAX(FX), .SLOW_MIN(SM), .SLOW_MAX(SX), .SEED(SEED_B)) peer (
        .clk(clk), .rst_n(rst_n), .restart(restart), .rx_sym(l12[DLY-1]),
        .tx_sym(peer_tx), .done(peer_done), .is_root(peer_root));

    // link delay lines
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DLY; i++) begin
                l12[i] <= 2'd0;
                l21[i] <= 2'd0;
            end
        end else begin
            l12[0] <= dut_tx;
            l21[0] <= peer_tx;
            for (int i = 1; i < DLY; i++) begin
                l12[i] <= l12[i-1];
                l21[i] <= l21[i-1];
            end
        end
    end

    // R3 register sequence as specified
    always @(posedge clk) begin
        if (!rst_n) mdl <= SEED_A;
        else        mdl <= {mdl[14:0], mdl[15] ^ mdl[13] ^ mdl[12] ^ mdl[10]};
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        prev_bit = mdl[0];
        @(negedge clk);
    endtask

    task automatic expect_idle(input string req);
        chk(dut_tx == 2'd3, req, dut_tx, 3);
        last_slow = prev_bit;
    endtask

    task automatic do_restart(input int n, input logic [1:0] rx_rel);
        restart = 1'b1;
        drv_rx  = 2'd0;
        repeat (n) step();
        chk(dut_done == 1'b0, "R12", dut_done, 0);
        restart = 1'b0;
        drv_rx  = rx_rel;
        step();
        drv_rx  = 2'd0;
    endtask

    // from the negedge where the opening idle is seen, run the wait
    task automatic watch(input int add, input logic [1:0] want, input string req,
                         input int ka, input logic [1:0] sa, input int kb, input logic [1:0] sb);
        int  win;
        bit  quiet;
        quiet = 1'b1;
        win   = (last_slow ? SM : FM) + 1 + add;
        for (int k = 0; k < win; k++) begin
            drv_rx = (k == ka) ? sa : ((k == kb) ? sb : 2'd0);
            step();
            if (k + 1 < win && dut_tx != 2'd0) quiet = 1'b0;
        end
        drv_rx = 2'd0;
        chk(quiet, "R2 silent wait", quiet, 1);
        chk(dut_tx == want, req, dut_tx, want);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int wt;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(dut_tx == 2'd0, "R1 tx", dut_tx, 0);
        chk(dut_done == 1'b0, "R1 done", dut_done, 0);
        chk(dut_root == 1'b0, "R1 root", dut_root, 0);
        rst_n = 1'b1;
        step();
        expect_idle("R1 first idle");
        watch(0, 2'd2, "R1/R8 ack after reset", -1, 0, -1, 0);
        chk(dut_done && dut_root, "R6 root flags", {dut_done, dut_root}, 3);

        for (int r = 0; r < 8; r++) begin
            // child path, idle ignored in sent-request, terminal ignores all
            do_restart(1, 2'd0);
            expect_idle("R12/R4 idle after restart");
            watch(0, 2'd1, "R3/R7/R8 request at window min", 0, 2'd3, -1, 0);
            drv_rx = 2'd3; step();
            chk(dut_tx == 2'd0 && !dut_done, "R10 idle ignored", {dut_tx, dut_done}, 0);
            drv_rx = 2'd2; step();
            chk(dut_done && !dut_root, "R10 child", {dut_done, dut_root}, 2);
            drv_rx = 2'd1; step();
            drv_rx = 2'd3; step();
            drv_rx = 2'd2; step();
            drv_rx = 2'd0;
            chk(dut_done && !dut_root && dut_tx == 2'd0, "R11 child holds",
                {dut_done, dut_root, dut_tx}, 8);

            // request-side wait ignores request and acknowledge
            do_restart(1, 2'd0);
            expect_idle("R4 idle");
            watch(0, 2'd2, "R13 ack unchanged", 3, 2'd1, 6, 2'd2);
            chk(dut_done && dut_root, "R6 root", {dut_done, dut_root}, 3);
            drv_rx = 2'd1; step();
            drv_rx = 2'd3; step();
            drv_rx = 2'd0;
            chk(dut_done && dut_root && dut_tx == 2'd0, "R11 root holds",
                {dut_done, dut_root, dut_tx}, 12);

            // idle-side wait ignores acknowledge
            do_restart(1, 2'd0);
            expect_idle("R4 idle");
            watch(0, 2'd1, "R13 req unchanged", 0, 2'd3, 5, 2'd2);

            // idle wait back to request wait keeps the count
            do_restart(1, 2'd0);
            expect_idle("R4 idle");
            watch(0, 2'd2, "R7/R6 count kept", 0, 2'd3, 4, 2'd1);

            // receive wins over expiry in the same cycle
            do_restart(1, 2'd0);
            expect_idle("R4 idle");
            watch(1, 2'd1, "R9 receive priority", last_slow ? SM : FM, 2'd3, -1, 0);

            // heard-idle path, then request crossing back to contention
            do_restart(1, 2'd3);
            chk(dut_tx == 2'd0, "R4 heard idle silent", dut_tx, 0);
            step();
            expect_idle("R5 idle from heard-idle");
            watch(0, 2'd1, "R5/R8 request", -1, 0, -1, 0);
            drv_rx = 2'd1; step(); drv_rx = 2'd0;
            chk(dut_tx == 2'd0 && !dut_done, "R10 back to contention", dut_tx, 0);
            step();
            expect_idle("R10 idle after crossing");
            watch(0, 2'd2, "R6/R8 ack", -1, 0, -1, 0);

            // heard-idle plus request returns to contention
            do_restart(1, 2'd3);
            drv_rx = 2'd1; step(); drv_rx = 2'd0;
            chk(dut_tx == 2'd0, "R5 request in heard-idle", dut_tx, 0);
            step();
            expect_idle("R5 idle after return");
        end

        // two nodes over delayed links
        link_mode = 1'b1;
        for (int r = 0; r < 16; r++) begin
            do_restart(DLY + 3, 2'd0);
            wt = 0;
            while (!(dut_done && peer_done) && wt < 3000) begin
                step();
                wt++;
            end
            chk(dut_done && peer_done, "R14 both finish", {dut_done, peer_done}, 3);
            chk(dut_root != peer_root, "R14 one root one child", {dut_root, peer_root}, 1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule